// File: doc/BRIEF.md
# DDS Serial Command Sequencer

This block programs the two 32-bit frequency tuning registers of an external direct digital synthesis device. The device takes 16-bit command frames over a three-wire serial write link: a serial clock, a data line and an active-low frame sync. A single start pulse makes the block capture both tuning words and send a fixed program of eleven frames. The program first holds the synthesizer in sleep, reset and clear. It then loads the tuning bytes, one command per byte, sets the sync and source-select controls, and finally releases reset and clear.

All serial timing comes from the system clock. The setup interval (clock high), the hold interval (clock low) and the idle gap after each frame are parameters given in clock cycles. The default gap is about one millisecond at 200 MHz, and a bench can shorten it. The block shows `busy` while the program runs and pulses `done` once the last frame has closed.

Top module: `dds_tuning_loader`

## Requirements
- R1: Each frame has 16 bits and goes out most significant bit first. The receiver takes each bit on a falling edge of `sclk`.
- R2: `fsync` falls while `sclk` is high, before the first bit of a frame. Exactly 16 falling edges of `sclk` occur while `fsync` is low, and `fsync` rises only after the 16th. Whenever `fsync` is high, `sclk` is high.
- R3: For every bit, `sclk` stays high for SETUP_CYC cycles with the data already on `sdata`, then stays low for HOLD_CYC cycles. `sdata` does not change while `sclk` is low.
- R4: The first frame of the program is 0xD000.
- R5: Frames 2 to 9 carry the bytes of tuning word 0 and then tuning word 1, least significant byte first, each in bits [7:0]. Their bits [15:8] are 0x30, 0x21, 0x32, 0x23, 0x34, 0x25, 0x36, 0x27, in that order.
- R6: Frame 10 is 0x9000 and frame 11 is 0xC000.
- R7: After every frame, `fsync` stays high for at least GAP_CYC cycles before the next frame begins.
- R8: Both tuning words are captured in the cycle that start is accepted; later changes on `tune0` and `tune1` do not affect the frames. A start that arrives while `busy` is high is ignored: the program runs once with its original words.
- R9: `done` is high for exactly one cycle, namely the cycle after `fsync` rises at the end of frame 11. `busy` is high from the cycle after an accepted start until the idle gap that follows the last frame has ended.
- R10: While reset is held, and just after it is released, `fsync` and `sclk` are high and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the program |
| tune0 | input | 32 | Tuning word 0, captured when start is accepted |
| tune1 | input | 32 | Tuning word 1, captured when start is accepted |
| sclk | output | 1 | Serial clock; idles high |
| sdata | output | 1 | Serial data, MSB first |
| fsync | output | 1 | Frame sync, low for the duration of a frame |
| busy | output | 1 | Program in progress |
| done | output | 1 | One-cycle pulse after the last frame ends |

## Verification
The bench decodes every frame from the serial lines. It compares each frame with an expected program that it builds from the tuning words, using all-zero, all-one and mixed-byte patterns. A byte-order or prefix error in the program table would therefore appear as a wrong frame. The bench measures every high and low phase of `sclk` and every gap between frames, which exposes off-by-one errors in the counters as a wrong phase length. Halfway through a run it changes the tuning inputs and pulses start again. A design that failed to capture the words would send corrupted bytes, and a design that accepted the second start would send extra frames. The bench also checks that `done` appears in exactly the cycle after the final `fsync` rise, so a pulse that comes one cycle early or late, or twice, is reported.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;

    localparam int FRAME_W  = 16;
    localparam int N_FRAMES = 11;
    localparam int IDX_W    = $clog2(N_FRAMES);

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_HIGH,
        SH_LOW,
        SH_TAIL
    } shift_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_GAP
    } seq_state_t;

    // Frame k of the program: a fixed opener, eight byte loads, then the
    // mode frame and the release frame.
    function automatic logic [FRAME_W-1:0] frame_word(
        input logic [IDX_W-1:0] idx,
        input logic [31:0]      w0,
        input logic [31:0]      w1
    );
        logic [2:0]  k;
        logic [31:0] w;
        logic [7:0]  b;
        k = 3'(idx - IDX_W'(1));
        w = k[2] ? w1 : w0;
        b = w[{k[1:0], 3'b000} +: 8];
        if (idx == '0)
            return 16'hD000;
        else if (idx == IDX_W'(9))
            return 16'h9000;
        else if (idx >= IDX_W'(10))
            return 16'hC000;
        else
            // upper byte: 0b001x_0kkk, x set on even byte slots
            return {3'b001, ~k[0], 1'b0, k, b};
    endfunction

endpackage

// File: rtl/dds_seq_program.sv
module dds_seq_program
    import dds_seq_pkg::*;
(
    input  logic [IDX_W-1:0]   idx,
    input  logic [31:0]        w0,
    input  logic [31:0]        w1,
    output logic [FRAME_W-1:0] word,
    output logic               last
);
    always_comb begin
        word = frame_word(idx, w0, w1);
        last = (idx == IDX_W'(N_FRAMES - 1));
    end
endmodule

// File: rtl/dds_seq_shifter.sv
module dds_seq_shifter
    import dds_seq_pkg::*;
#(
    parameter int SETUP_CYC = 20,
    parameter int HOLD_CYC  = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [FRAME_W-1:0] word,
    output logic               sclk,
    output logic               sdata,
    output logic               fsync,
    output logic               frame_end,
    output logic               idle
);
    localparam int MAXC = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int BW   = $clog2(FRAME_W);

    shift_state_t       st;
    logic [CW-1:0]      cnt;
    logic [BW-1:0]      bits_left;
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SH_IDLE;
            cnt       <= '0;
            bits_left <= '0;
            shreg     <= '0;
            sclk      <= 1'b1;
            sdata     <= 1'b0;
            fsync     <= 1'b1;
            frame_end <= 1'b0;
        end else begin
            frame_end <= 1'b0;
            case (st)
                SH_IDLE: if (go) begin
                    shreg     <= word;
                    sdata     <= word[FRAME_W-1];
                    fsync     <= 1'b0;
                    sclk      <= 1'b1;
                    cnt       <= '0;
                    bits_left <= BW'(FRAME_W - 1);
                    st        <= SH_HIGH;
                end
                SH_HIGH: if (cnt == CW'(SETUP_CYC - 1)) begin
                    cnt  <= '0;
                    sclk <= 1'b0;
                    st   <= SH_LOW;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                SH_LOW: if (cnt == CW'(HOLD_CYC - 1)) begin
                    cnt  <= '0;
                    sclk <= 1'b1;
                    if (bits_left == '0) begin
                        st <= SH_TAIL;
                    end else begin
                        bits_left <= bits_left - 1'b1;
                        shreg     <= shreg << 1;
                        sdata     <= shreg[FRAME_W-2];
                        st        <= SH_HIGH;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
                SH_TAIL: if (cnt == CW'(SETUP_CYC - 1)) begin
                    cnt       <= '0;
                    fsync     <= 1'b1;
                    frame_end <= 1'b1;
                    st        <= SH_IDLE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    assign idle = (st == SH_IDLE);

    // R2
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        fsync |-> sclk);

    // R3
    data_stable_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!sclk && !$past(sclk)) |-> $stable(sdata));

    // R2
    all_bits_sent_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fsync) |-> (bits_left == '0));

endmodule

// File: rtl/dds_tuning_loader.sv
module dds_tuning_loader
    import dds_seq_pkg::*;
#(
    parameter int SETUP_CYC = 20,
    parameter int HOLD_CYC  = 20,
    parameter int GAP_CYC   = 200000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] tune0,
    input  logic [31:0] tune1,
    output logic        sclk,
    output logic        sdata,
    output logic        fsync,
    output logic        busy,
    output logic        done
);
    localparam int GW = $clog2(GAP_CYC + 1);

    seq_state_t         st;
    logic [IDX_W-1:0]   idx;
    logic [GW-1:0]      gcnt;
    logic [31:0]        w0_q, w1_q;
    logic [FRAME_W-1:0] cur_word;
    logic               cur_last;
    logic               frame_go, frame_end, sh_idle;

    dds_seq_program u_prog (
        .idx  (idx),
        .w0   (w0_q),
        .w1   (w1_q),
        .word (cur_word),
        .last (cur_last)
    );

    dds_seq_shifter #(
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .go        (frame_go),
        .word      (cur_word),
        .sclk      (sclk),
        .sdata     (sdata),
        .fsync     (fsync),
        .frame_end (frame_end),
        .idle      (sh_idle)
    );

    assign frame_go = (st == SQ_ISSUE);
    assign busy     = (st != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SQ_IDLE;
            idx  <= '0;
            gcnt <= '0;
            w0_q <= '0;
            w1_q <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SQ_IDLE: if (start) begin
                    w0_q <= tune0;
                    w1_q <= tune1;
                    idx  <= '0;
                    st   <= SQ_ISSUE;
                end
                SQ_ISSUE: st <= SQ_WAIT;
                SQ_WAIT: if (frame_end) begin
                    done <= cur_last;
                    gcnt <= '0;
                    st   <= SQ_GAP;
                end
                SQ_GAP: if (gcnt == GW'(GAP_CYC - 1)) begin
                    if (cur_last) begin
                        st <= SQ_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= SQ_ISSUE;
                    end
                end else begin
                    gcnt <= gcnt + 1'b1;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R8
    words_held_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(w0_q) && $stable(w1_q)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_after_sync_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(frame_end) && fsync));

    // R7
    issue_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        frame_go |-> (sh_idle && fsync));

endmodule

// File: tb/tb_dds_tuning_loader.sv
module tb_dds_tuning_loader;
    localparam int SETUP = 2;
    localparam int HOLD  = 3;
    localparam int GAP   = 20;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [31:0] tune0 = '0, tune1 = '0;
    logic sclk, sdata, fsync, busy, done;

    always #2.5 clk = ~clk;

    dds_tuning_loader #(.SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .GAP_CYC(GAP)) dut (
        .clk(clk), .rst(rst), .start(start), .tune0(tune0), .tune1(tune1),
        .sclk(sclk), .sdata(sdata), .fsync(fsync), .busy(busy), .done(done)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [15:0] expw [11];
    bit mon_en = 0;
    int frames_seen, done_cnt, bits, highc, lowc, gapc;
    logic [15:0] cap;
    logic pf, ps, psd;
    bit dchk;

    always @(negedge clk) begin
        if (mon_en) begin
            if (dchk) begin
                chk(done === 1'b1, "R9 done after last sync", done, 1);
                dchk = 0;
            end
            if (done === 1'b1) done_cnt++;
            if (!fsync && ps && !sclk) ; // placeholder-free: nothing
            if (pf && !fsync) begin
                chk(sclk === 1'b1, "R2 sclk high at sync fall", sclk, 1);
                if (frames_seen > 0) chk(gapc >= GAP, "R7 gap", gapc, GAP);
                bits = 0; cap = '0; highc = 1;
            end else if (!fsync) begin
                if (ps && !sclk) begin
                    cap = {cap[14:0], sdata};
                    bits++;
                    chk(highc == SETUP, "R3 high phase", highc, SETUP);
                    lowc = 1;
                end else if (!ps && sclk) begin
                    chk(lowc == HOLD, "R3 low phase", lowc, HOLD);
                    highc = 1;
                end else if (sclk) begin
                    highc++;
                end else begin
                    lowc++;
                    chk(sdata === psd, "R3 data stable while low", sdata, psd);
                end
            end
            if (!pf && fsync) begin
                chk(bits == 16, "R2 bit count", bits, 16);
                if (frames_seen < 11) begin
                    if (frames_seen == 0)
                        chk(cap == expw[0], "R4 R1 frame", cap, expw[0]);
                    else if (frames_seen < 9)
                        chk(cap == expw[frames_seen], "R5 R1 frame", cap, expw[frames_seen]);
                    else
                        chk(cap == expw[frames_seen], "R6 R1 frame", cap, expw[frames_seen]);
                end else begin
                    chk(0, "R8 extra frame", frames_seen, 10);
                end
                frames_seen++;
                gapc = 1;
                if (frames_seen == 11) begin
                    chk(done === 1'b0, "R9 done not early", done, 0);
                    dchk = 1;
                end
            end else if (fsync) begin
                gapc++;
            end
            if (fsync) chk(sclk === 1'b1, "R2 sclk idle high", sclk, 1);
        end
        pf = fsync; ps = sclk; psd = sdata;
    end

    task automatic run(input logic [31:0] a, input logic [31:0] b, input bit inject);
        expw[0]  = 16'hD000;
        expw[1]  = {8'h30, a[7:0]};
        expw[2]  = {8'h21, a[15:8]};
        expw[3]  = {8'h32, a[23:16]};
        expw[4]  = {8'h23, a[31:24]};
        expw[5]  = {8'h34, b[7:0]};
        expw[6]  = {8'h25, b[15:8]};
        expw[7]  = {8'h36, b[23:16]};
        expw[8]  = {8'h27, b[31:24]};
        expw[9]  = 16'h9000;
        expw[10] = 16'hC000;
        frames_seen = 0; done_cnt = 0; gapc = 0;
        @(negedge clk);
        tune0 = a; tune1 = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tune0 = ~a ^ 32'h5A5A_0F0F; tune1 = ~b;
        chk(busy === 1'b1, "R9 busy after start", busy, 1);
        if (inject) begin
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy === 1'b1) @(negedge clk);
        chk(frames_seen == 11, "R8 frame count", frames_seen, 11);
        chk(done_cnt == 1, "R9 single done", done_cnt, 1);
        chk(fsync === 1'b1 && sclk === 1'b1, "R10 idle lines", {fsync, sclk}, 2'b11);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs under reset
        chk(fsync === 1'b1 && sclk === 1'b1, "R10 lines in reset", {fsync, sclk}, 2'b11);
        chk(busy === 1'b0 && done === 1'b0, "R10 status in reset", {busy, done}, 2'b00);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && fsync === 1'b1, "R10 after reset", {busy, fsync}, 2'b01);
        pf = fsync; ps = sclk; psd = sdata;
        mon_en = 1;
        run(32'h0000_0000, 32'h0000_0000, 0);
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run(32'h1234_5678, 32'h89AB_CDEF, 1);
        run(32'h8000_0001, 32'h0180_7E00, 1);
        run(32'hA5C3_3C5A, 32'hDEAD_BEEF, 0);
        for (int s = 0; s < 4; s++)
            run(32'h1 << (s * 8 + 3), 32'hFF << (s * 8), s[0]);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule